// File: doc/BRIEF.md
# Privilege-Checked Thread Identifier Register Bank

This block is a bank of three software-owned identifier words. It sits behind a system-coprocessor register access port. Each request arrives with a valid strobe, a read/write flag, a privilege flag, a write data word and four selector fields: a 3-bit primary opcode, a 4-bit primary register number, a 4-bit secondary register number and a 3-bit secondary opcode. The block decodes the selector and applies a permission rule that differs for each register. It returns read data and reports in the same cycle whether the access is undefined or is not handled by this bank.

The three words change only when software writes them with enough privilege. One word is open to every mode. One word can be read by unprivileged code, but only privileged code can write it. One word is reserved for privileged code. The register number one above the bank's own is an unallocated space, and any access to it is flagged as undefined. Bank-space selectors that pick none of the three slots raise a not-handled flag, so that a neighbouring decoder can answer them.

Top module: `tid_bank`

## Requirements
- R1: A synchronous active-high reset clears all three words to zero, and a permitted read after reset returns zero.
- R2: A request selects the bank when primary opcode = 0, primary register = 13 and secondary register = 0. Secondary opcode 2 selects the open word, 3 selects the user-readable word and 4 selects the privileged word. The three words are distinct storage.
- R3: The open word (secondary opcode 2) can be read and written in both privileged and unprivileged mode, with no undefined flag.
- R4: The user-readable word (secondary opcode 3) can be read in either mode. An unprivileged write to it raises the undefined flag and leaves the word unchanged. A privileged write to it updates the word.
- R5: Any unprivileged read or write of the privileged word (secondary opcode 4) raises the undefined flag, returns zero data and leaves the word unchanged. Privileged reads and writes of it are allowed.
- R6: Any valid request with primary register = 14 raises the undefined flag, whatever the other fields, the privilege and the direction. It returns zero data and changes no word.
- R7: A bank-space selector with secondary opcode other than 2, 3 or 4 raises the not-handled flag, does not raise the undefined flag, returns zero data and changes no word.
- R8: A permitted write commits at the rising clock edge of its request cycle. A read in a later cycle returns the new value. A read returns the stored value combinationally. Read data is zero for any write request.
- R9: When the valid strobe is low, both flags are low, read data is zero and no word changes.
- R10: A selector that is neither bank space nor primary register 14 raises no flag, returns zero data and changes no word. This covers, for example, primary register 13 with a nonzero primary opcode or a nonzero secondary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_vld | input | 1 | Request valid strobe |
| req_wr | input | 1 | 1 = write, 0 = read |
| req_priv | input | 1 | 1 = privileged mode, 0 = unprivileged |
| req_wdata | input | 32 | Write data |
| sel_op1 | input | 3 | Primary opcode field of the selector |
| sel_crn | input | 4 | Primary register number field |
| sel_crm | input | 4 | Secondary register number field |
| sel_op2 | input | 3 | Secondary opcode field |
| rsp_rdata | output | 32 | Read data; zero unless the request is a permitted read |
| rsp_undef | output | 1 | Undefined access: permission refused or unallocated space |
| rsp_nohit | output | 1 | Bank-space selector not handled by this bank |

## Verification
Two things happen in the same request cycle: the permission check refuses an access, and the storage's write enable acts at the closing edge. A refused write must raise the undefined flag and must also be blocked from committing in that same cycle. The bench provokes this with unprivileged writes to the user-readable and privileged words. It follows each one at once with a privileged read, and judges that read against a reference copy that only permitted writes update. Back-to-back write-then-read pairs check that a commit is visible exactly one cycle later and not in its own cycle.

// File: rtl/tid_pkg.sv
package tid_pkg;

   // Slot order inside the bank follows the secondary opcode order.
   typedef enum logic [1:0] {
      SLOT_OPEN = 2'd0,
      SLOT_UREAD = 2'd1,
      SLOT_PRIV = 2'd2,
      SLOT_NONE = 2'd3
   } slot_e;

   // Access classification produced by the permission stage.
   typedef struct packed {
      logic undef;
      logic nohit;
      logic deny;
   } acc_cls_t;

endpackage

// File: rtl/tid_decode.sv
module tid_decode #(
   parameter int OP1_W     = 3,
   parameter int CRN_W     = 4,
   parameter int CRM_W     = 4,
   parameter int OP2_W     = 3,
   parameter int BANK_CRN  = 13,
   parameter int HOLE_CRN  = 14,
   parameter int FIRST_OP2 = 2,
   parameter int NUM_REGS  = 3
) (
   input  logic             vld,
   input  logic [OP1_W-1:0] op1,
   input  logic [CRN_W-1:0] crn,
   input  logic [CRM_W-1:0] crm,
   input  logic [OP2_W-1:0] op2,
   output logic [NUM_REGS-1:0] slot_oh,
   output logic             hit,
   output logic             nohit,
   output logic             hole
);

   logic bank_space;

   always_comb begin
      bank_space = vld && (op1 == '0) && (int'(crn) == BANK_CRN) && (crm == '0);
      hole       = vld && (int'(crn) == HOLE_CRN);
   end

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
      assign slot_oh[i] = bank_space && (int'(op2) == FIRST_OP2 + i);
   end

   assign hit   = |slot_oh;
   assign nohit = bank_space && !hit;

endmodule

// File: rtl/tid_guard.sv
module tid_guard
   import tid_pkg::*;
#(
   parameter int NUM_REGS = 3,
   parameter logic [NUM_REGS-1:0] USER_RD_MASK = 3'b011,
   parameter logic [NUM_REGS-1:0] USER_WR_MASK = 3'b001
) (
   input  logic [NUM_REGS-1:0] slot_oh,
   input  logic                nohit,
   input  logic                hole,
   input  logic                wr,
   input  logic                priv,
   output logic [NUM_REGS-1:0] wr_en_oh,
   output logic [NUM_REGS-1:0] rd_en_oh,
   output acc_cls_t            cls
);

   logic [NUM_REGS-1:0] ok;

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_perm
      logic rd_ok, wr_ok;
      assign rd_ok       = priv || USER_RD_MASK[i];
      assign wr_ok       = priv || USER_WR_MASK[i];
      assign ok[i]       = wr ? wr_ok : rd_ok;
      assign wr_en_oh[i] = slot_oh[i] && wr && ok[i];
      assign rd_en_oh[i] = slot_oh[i] && !wr && ok[i];
   end

   always_comb begin
      cls.deny  = |(slot_oh & ~ok);
      cls.undef = hole || cls.deny;
      cls.nohit = nohit;
   end

endmodule

// File: rtl/tid_store.sv
module tid_store #(
   parameter int DATA_W   = 32,
   parameter int NUM_REGS = 3
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic [NUM_REGS-1:0]        wr_en_oh,
   input  logic [NUM_REGS-1:0]        rd_en_oh,
   input  logic [DATA_W-1:0]          wdata,
   output logic [DATA_W-1:0]          rdata,
   output logic [NUM_REGS*DATA_W-1:0] bank_flat
);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (rst)
            word_q <= '0;
         else if (wr_en_oh[i])
            word_q <= wdata;
      end
      assign bank_flat[i*DATA_W +: DATA_W] = word_q;
   end

   // AND-OR read mux; one-hot enable, so no priority chain.
   always_comb begin
      rdata = '0;
      for (int i = 0; i < NUM_REGS; i++)
         rdata |= bank_flat[i*DATA_W +: DATA_W] & {DATA_W{rd_en_oh[i]}};
   end

endmodule

// File: rtl/tid_bank.sv
module tid_bank
   import tid_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int OP1_W     = 3,
   parameter int CRN_W     = 4,
   parameter int CRM_W     = 4,
   parameter int OP2_W     = 3,
   parameter int BANK_CRN  = 13,
   parameter int HOLE_CRN  = 14,
   parameter int FIRST_OP2 = 2,
   parameter int NUM_REGS  = 3,
   parameter logic [NUM_REGS-1:0] USER_RD_MASK = 3'b011,
   parameter logic [NUM_REGS-1:0] USER_WR_MASK = 3'b001
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_vld,
   input  logic              req_wr,
   input  logic              req_priv,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [OP1_W-1:0]  sel_op1,
   input  logic [CRN_W-1:0]  sel_crn,
   input  logic [CRM_W-1:0]  sel_crm,
   input  logic [OP2_W-1:0]  sel_op2,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_undef,
   output logic              rsp_nohit
);

   localparam int LAST_OP2 = FIRST_OP2 + NUM_REGS - 1;

   if (DATA_W < 1) begin : g_bad_width
      $error("tid_bank: DATA_W must be positive");
   end
   if (LAST_OP2 >= (1 << OP2_W)) begin : g_bad_op2
      $error("tid_bank: slot range exceeds secondary opcode field");
   end
   if (BANK_CRN == HOLE_CRN) begin : g_bad_crn
      $error("tid_bank: bank and unallocated register numbers collide");
   end
   if (BANK_CRN >= (1 << CRN_W) || HOLE_CRN >= (1 << CRN_W)) begin : g_bad_crn_w
      $error("tid_bank: register number does not fit its field");
   end

   logic [NUM_REGS-1:0]        slot_oh, wr_en_oh, rd_en_oh;
   logic                       hit, nohit, hole;
   acc_cls_t                   cls;
   logic [NUM_REGS*DATA_W-1:0] bank_flat;
   logic                       hit_unused;

   tid_decode #(
      .OP1_W(OP1_W), .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W),
      .BANK_CRN(BANK_CRN), .HOLE_CRN(HOLE_CRN),
      .FIRST_OP2(FIRST_OP2), .NUM_REGS(NUM_REGS)
   ) u_decode (
      .vld(req_vld), .op1(sel_op1), .crn(sel_crn), .crm(sel_crm), .op2(sel_op2),
      .slot_oh(slot_oh), .hit(hit), .nohit(nohit), .hole(hole)
   );

   assign hit_unused = hit;

   tid_guard #(
      .NUM_REGS(NUM_REGS), .USER_RD_MASK(USER_RD_MASK), .USER_WR_MASK(USER_WR_MASK)
   ) u_guard (
      .slot_oh(slot_oh), .nohit(nohit), .hole(hole),
      .wr(req_wr), .priv(req_priv),
      .wr_en_oh(wr_en_oh), .rd_en_oh(rd_en_oh), .cls(cls)
   );

   tid_store #(
      .DATA_W(DATA_W), .NUM_REGS(NUM_REGS)
   ) u_store (
      .clk(clk), .rst(rst),
      .wr_en_oh(wr_en_oh), .rd_en_oh(rd_en_oh), .wdata(req_wdata),
      .rdata(rsp_rdata), .bank_flat(bank_flat)
   );

   assign rsp_undef = cls.undef;
   assign rsp_nohit = cls.nohit && !hit_unused;

endmodule

// File: rtl/tid_bank_chk.sv
module tid_bank_chk #(
   parameter int DATA_W    = 32,
   parameter int OP1_W     = 3,
   parameter int CRN_W     = 4,
   parameter int CRM_W     = 4,
   parameter int OP2_W     = 3,
   parameter int BANK_CRN  = 13,
   parameter int HOLE_CRN  = 14,
   parameter int FIRST_OP2 = 2,
   parameter int NUM_REGS  = 3
) (
   input logic                       clk,
   input logic                       rst,
   input logic                       req_vld,
   input logic                       req_wr,
   input logic                       req_priv,
   input logic [OP1_W-1:0]           sel_op1,
   input logic [CRN_W-1:0]           sel_crn,
   input logic [CRM_W-1:0]           sel_crm,
   input logic [OP2_W-1:0]           sel_op2,
   input logic [DATA_W-1:0]          rsp_rdata,
   input logic                       rsp_undef,
   input logic                       rsp_nohit,
   input logic [NUM_REGS*DATA_W-1:0] bank_flat
);

   logic in_bank;
   assign in_bank = (sel_op1 == '0) && (int'(sel_crn) == BANK_CRN) && (sel_crm == '0);

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      $past(rst) |-> bank_flat == '0);

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !req_vld |-> (!rsp_undef && !rsp_nohit && rsp_rdata == '0));

   // R6
   hole_undef_chk: assert property (@(posedge clk) disable iff (rst)
      (req_vld && int'(sel_crn) == HOLE_CRN) |-> (rsp_undef && rsp_rdata == '0));

   // R5
   priv_slot_undef_chk: assert property (@(posedge clk) disable iff (rst)
      (req_vld && !req_priv && in_bank && int'(sel_op2) == FIRST_OP2 + 2)
      |-> (rsp_undef && rsp_rdata == '0));

   // R4
   uread_wr_block_chk: assert property (@(posedge clk) disable iff (rst)
      (req_vld && req_wr && !req_priv && in_bank && int'(sel_op2) == FIRST_OP2 + 1)
      |=> $stable(bank_flat));

   // R7
   nohit_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_nohit |-> !rsp_undef);

   // R7
   nohit_stable_chk: assert property (@(posedge clk) disable iff (rst)
      rsp_nohit |=> $stable(bank_flat));

   // R9
   idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
      !req_vld |=> $stable(bank_flat));

endmodule

bind tid_bank tid_bank_chk #(
   .DATA_W(DATA_W), .OP1_W(OP1_W), .CRN_W(CRN_W), .CRM_W(CRM_W), .OP2_W(OP2_W),
   .BANK_CRN(BANK_CRN), .HOLE_CRN(HOLE_CRN), .FIRST_OP2(FIRST_OP2), .NUM_REGS(NUM_REGS)
) u_chk (
   .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .req_priv(req_priv),
   .sel_op1(sel_op1), .sel_crn(sel_crn), .sel_crm(sel_crm), .sel_op2(sel_op2),
   .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef), .rsp_nohit(rsp_nohit),
   .bank_flat(bank_flat)
);

// File: tb/test_tid_bank.sv
module test_tid_bank;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        req_vld = 1'b0, req_wr = 1'b0, req_priv = 1'b0;
   logic [31:0] req_wdata = '0;
   logic [2:0]  sel_op1 = '0, sel_op2 = '0;
   logic [3:0]  sel_crn = '0, sel_crm = '0;
   logic [31:0] rsp_rdata;
   logic        rsp_undef, rsp_nohit;

   always #2 clk = ~clk;   // 250 MHz

   tid_bank i_tid_bank (
      .clk(clk), .rst(rst), .req_vld(req_vld), .req_wr(req_wr), .req_priv(req_priv),
      .req_wdata(req_wdata), .sel_op1(sel_op1), .sel_crn(sel_crn), .sel_crm(sel_crm),
      .sel_op2(sel_op2), .rsp_rdata(rsp_rdata), .rsp_undef(rsp_undef),
      .rsp_nohit(rsp_nohit)
   );

   typedef struct {
      logic [31:0] rdata;
      logic        undef;
      logic        nohit;
      string       tag;
   } exp_t;

   exp_t        sb_q[$];
   logic [31:0] model [3];
   int          checks = 0;
   int          errors = 0;
   bit          done = 0;

   // Monitor: compares one response per driven request.
   initial begin
      forever begin
         @(negedge clk);
         #1;
         if (sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            checks++;
            if (rsp_rdata !== e.rdata || rsp_undef !== e.undef || rsp_nohit !== e.nohit) begin
               errors++;
               $display("FAIL %s: got rdata=%h undef=%b nohit=%b, expected rdata=%h undef=%b nohit=%b",
                        e.tag, rsp_rdata, rsp_undef, rsp_nohit, e.rdata, e.undef, e.nohit);
            end
         end
      end
   end

   // Driver: applies one request and pushes the expected response.
   task automatic acc(input bit vld, input bit wr, input bit priv, input logic [2:0] op1,
                      input logic [3:0] crn, input logic [3:0] crm, input logic [2:0] op2,
                      input logic [31:0] wd, input string tag);
      exp_t e;
      bit   bank, hit, hole, deny;
      int   idx;
      @(negedge clk);
      req_vld = vld; req_wr = wr; req_priv = priv; req_wdata = wd;
      sel_op1 = op1; sel_crn = crn; sel_crm = crm; sel_op2 = op2;
      bank = (op1 == 0) && (crn == 13) && (crm == 0);
      idx  = int'(op2) - 2;
      hit  = bank && idx >= 0 && idx <= 2;
      hole = (crn == 14);
      deny = hit && !priv && (idx == 2 || (idx == 1 && wr));
      e.tag   = tag;
      e.undef = vld && (hole || deny);
      e.nohit = vld && bank && !hit;
      e.rdata = (vld && hit && !deny && !wr) ? model[idx] : 32'h0;
      sb_q.push_back(e);
      if (vld && hit && !deny && wr) model[idx] = wd;
   endtask

   task automatic idle();
      @(negedge clk);
      req_vld = 1'b0;
   endtask

   task automatic rd(input bit priv, input logic [2:0] op2, input string tag);
      acc(1, 0, priv, 3'd0, 4'd13, 4'd0, op2, 32'h0, tag);
   endtask

   task automatic wr(input bit priv, input logic [2:0] op2, input logic [31:0] d, input string tag);
      acc(1, 1, priv, 3'd0, 4'd13, 4'd0, op2, d, tag);
   endtask

   task automatic do_reset();
      @(negedge clk);
      req_vld = 1'b0;
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < 3; i++) model[i] = 32'h0;
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 3; i++) model[i] = 32'hFFFF_FFFF;
      do_reset();

      // R1: reset state
      rd(1, 3'd2, "R1 open after reset");
      rd(1, 3'd3, "R1 uread after reset");
      rd(1, 3'd4, "R1 priv after reset");

      // R2: distinct slots
      wr(1, 3'd2, 32'h1111_AAAA, "R2 write open");
      wr(1, 3'd3, 32'h2222_BBBB, "R2 write uread");
      wr(1, 3'd4, 32'h3333_CCCC, "R2 write priv");
      rd(1, 3'd2, "R2 read open");
      rd(1, 3'd3, "R2 read uread");
      rd(1, 3'd4, "R2 read priv");

      // R8: commit visible the next cycle, old value before
      rd(0, 3'd2, "R8 read before write");
      wr(0, 3'd2, 32'hDEAD_0001, "R8 write");
      rd(0, 3'd2, "R8 read right after write");

      // R3: open word from user mode
      wr(0, 3'd2, 32'h0BAD_F00D, "R3 user write open");
      rd(0, 3'd2, "R3 user read open");
      rd(1, 3'd2, "R3 priv read open");

      // R4: user-readable word
      rd(0, 3'd3, "R4 user read uread");
      wr(0, 3'd3, 32'h5555_5555, "R4 user write uread refused");
      rd(1, 3'd3, "R4 uread unchanged");
      wr(1, 3'd3, 32'h6666_6666, "R4 priv write uread");
      rd(0, 3'd3, "R4 uread updated");

      // R5: privileged word
      rd(0, 3'd4, "R5 user read priv refused");
      wr(0, 3'd4, 32'h7777_7777, "R5 user write priv refused");
      rd(1, 3'd4, "R5 priv unchanged");
      wr(1, 3'd4, 32'h8888_8888, "R5 priv write priv");
      rd(1, 3'd4, "R5 priv updated");

      // R6: unallocated register number
      acc(1, 0, 0, 3'd0, 4'd14, 4'd0, 3'd2, 32'h0, "R6 user read hole");
      acc(1, 1, 1, 3'd0, 4'd14, 4'd0, 3'd2, 32'h9999_0000, "R6 priv write hole");
      acc(1, 1, 0, 3'd5, 4'd14, 4'd3, 3'd7, 32'h9999_0001, "R6 odd fields hole");
      rd(1, 3'd2, "R6 open unchanged");

      // R7: bank space, unhandled secondary opcodes
      for (int k = 0; k < 8; k++) begin
         if (k < 2 || k > 4) begin
            acc(1, 1, 1, 3'd0, 4'd13, 4'd0, 3'(k), 32'hA000_0000 + k, "R7 write nohit");
            acc(1, 0, 0, 3'd0, 4'd13, 4'd0, 3'(k), 32'h0, "R7 read nohit");
         end
      end
      rd(1, 3'd2, "R7 open unchanged");
      rd(1, 3'd3, "R7 uread unchanged");
      rd(1, 3'd4, "R7 priv unchanged");

      // R9: valid low
      acc(0, 1, 1, 3'd0, 4'd13, 4'd0, 3'd2, 32'hBEEF_BEEF, "R9 idle write");
      acc(0, 0, 0, 3'd0, 4'd14, 4'd0, 3'd4, 32'h0, "R9 idle hole");
      acc(0, 0, 1, 3'd0, 4'd13, 4'd0, 3'd6, 32'h0, "R9 idle nohit");
      rd(1, 3'd2, "R9 open unchanged");

      // R10: outside selectors
      acc(1, 1, 1, 3'd1, 4'd13, 4'd0, 3'd2, 32'hC0C0_C0C0, "R10 op1 nonzero");
      acc(1, 1, 1, 3'd0, 4'd13, 4'd1, 3'd3, 32'hC1C1_C1C1, "R10 crm nonzero");
      acc(1, 1, 1, 3'd0, 4'd12, 4'd0, 3'd4, 32'hC2C2_C2C2, "R10 other crn");
      rd(1, 3'd2, "R10 open unchanged");
      rd(1, 3'd3, "R10 uread unchanged");
      rd(1, 3'd4, "R10 priv unchanged");

      // Mixed traffic, every requirement's rules at once
      for (int n = 0; n < 400; n++) begin
         int   c;
         logic [2:0] op1;
         logic [3:0] crn, crm;
         c   = $urandom % 8;
         crn = (c < 5) ? 4'd13 : (c < 7 ? 4'd14 : 4'd12);
         op1 = ($urandom % 6 == 0) ? 3'd1 : 3'd0;
         crm = ($urandom % 6 == 0) ? 4'd2 : 4'd0;
         acc(($urandom % 8) != 0, $urandom % 2, $urandom % 2, op1, crn, crm,
             3'($urandom % 8), $urandom, "R2 mixed traffic");
      end

      // R1: reset in mid-run clears written words
      wr(1, 3'd4, 32'h1234_5678, "R1 prewrite");
      do_reset();
      rd(1, 3'd2, "R1 open after second reset");
      rd(1, 3'd3, "R1 uread after second reset");
      rd(1, 3'd4, "R1 priv after second reset");

      idle();
      repeat (3) @(negedge clk);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule